// File: doc/BRIEF.md
# Three-Channel Interval Timer

Three independent 16-bit down-counters sit behind an 8-bit host register bus. Each counter has its own data port. A shared control port configures a counter, freezes its count for reading, or captures count and status from several counters at once. Each channel counts only on cycles where its tick enable is high, so the counting rate is set by whatever drives the enables. Channels 0 and 1 take their gates from pins. Channel 2 takes its gate from a small auxiliary register, which also drives a speaker-enable pin and reports channel 2's output level.

Three counting behaviours are available. The first is a one-time output rise at terminal count. The second is a continuous square wave that decrements by two per tick. The third is a single one-tick low strobe. A reload value is staged when written and moves into the counter on the next tick, so software sees a short delay before a new count acts. Reads go through a per-channel byte sequencer. A held snapshot or a status byte, once captured, takes priority over the live count.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every timer output, `spk_en` and `aux_rdata` are 0.
- R2: A write to address 3 with bits 7:6 = 0..2 and bits 5:4 ≠ 00 configures that channel:
  - bits 3:1 give the mode (000 terminal count, x11 square wave, 100 strobe; other codes act as terminal count).
  - The output goes low for terminal count and high otherwise.
  - The write-byte and read-byte sequencers restart at the low byte.
- R3: The access field (bits 5:4) sets how a data-port write loads the reload value:
  - 01 loads the low byte and clears the high byte.
  - 10 loads the high byte and clears the low byte.
  - 11 takes the low byte and then the high byte.
- R4: A completed reload value enters the counter on the first tick after the write, whatever the gate level. That tick does not decrement.
- R5: In terminal-count mode the output rises on the Nth gated tick after the load tick. It then stays high until a new count is written, and completing that write drives it low.
- R6: In square-wave mode the count starts at N with bit 0 cleared and falls by 2 per gated tick. The output toggles every floor(N/2) ticks, and the first toggle comes floor(N/2) ticks after the load tick.
- R7: In strobe mode the output drops low on the Nth gated tick after the load tick. It is high again on the next tick and does not pulse again for that count.
- R8: A reload value of 0 counts as 65536.
- R9: While a channel's gate is low its count does not change.
- R10: Writing 00 in bits 5:4 snapshots the channel's count.
  - Data-port reads return the snapshot in the byte order of the access field; the snapshot is released after the last byte.
  - The counter keeps running underneath.
  - A further snapshot command while one is held is ignored.
- R11: A write of 11 in bits 7:6 is a capture command:
  - Bits 1, 2 and 3 select channels 0, 1 and 2.
  - Bit 5 = 0 captures the count and bit 4 = 0 captures status.
  - The status byte is {out, reload-pending, access[1:0], mode[2:0], 0} and is read before any captured count.
- R12: An `aux_wr` write sets channel 2's gate from bit 0 and `spk_en` from bit 1. `aux_rdata` shows the gate on bit 0, the speaker enable on bit 1 and channel 2's output on bit 4, with all other bits 0.
- R13: With nothing captured, a data-port read returns the live count, with bytes chosen by the access field. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 2 | Register address: 0..2 data ports, 3 control port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; advances read sequencing at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| aux_wr | input | 1 | Write strobe for the auxiliary register (data on `bus_wdata`) |
| aux_rdata | output | 8 | Auxiliary register read value |
| tick_en | input | 3 | Per-channel counting clock enable |
| gate_in | input | 2 | Gates of channels 0 and 1 |
| tmr_out | output | 3 | Channel outputs |
| spk_en | output | 1 | Speaker enable from the auxiliary register |

## Verification
The bench uses the default byte width of 8, which gives 16-bit counters. With that width, a full zero-means-65536 count completes in about 65,537 cycles, within the run budget, so the wrap boundary is reached directly rather than by scaling. Holding every tick enable high makes each tick a clock cycle. Edge timings then become exact cycle counts, and pulling a gate low freezes a count so that captures and status bytes have known values.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    K_TERM   = 2'd0,
    K_SQUARE = 2'd1,
    K_STROBE = 2'd2
  } cnt_kind_e;

  function automatic cnt_kind_e kind_of(input logic [2:0] m);
    if (m[1:0] == 2'b11) return K_SQUARE;
    else if (m == 3'b100) return K_STROBE;
    else return K_TERM;
  endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tri_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              ctl_wr_i,
  input  logic              snap_cmd_i,
  input  logic              rb_cnt_i,
  input  logic              rb_stat_i,
  input  logic              dat_wr_i,
  input  logic              dat_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [2:0]        mode_q, mode_d;
  logic [1:0]        acc_q, acc_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [CNT_W-1:0]  snap_q, snap_d;
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic out_q, out_d, pend_q, pend_d, run_q, run_d, armed_q, armed_d;
  logic wr_hi_q, wr_hi_d, rd_hi_q, rd_hi_d, snap_v_q, snap_v_d, stat_v_q, stat_v_d;

  cnt_kind_e        kind;
  logic             commit;
  logic             sel_hi, last_byte;
  logic [CNT_W-1:0] src, reload_even;

  assign kind        = kind_of(mode_q);
  assign reload_even = {reload_q[CNT_W-1:1], 1'b0};
  assign sel_hi      = (acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && rd_hi_q);
  assign last_byte   = (acc_q != ACC_LOHI) || rd_hi_q;
  assign src         = snap_v_q ? snap_q : count_q;
  assign rdata_o     = stat_v_q ? stat_q : (sel_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0]);
  assign out_o       = out_q;
  assign commit      = dat_wr_i && ((acc_q != ACC_LOHI) || wr_hi_q);

  always_comb begin
    mode_d = mode_q;   acc_d = acc_q;     reload_d = reload_q; count_d = count_q;
    snap_d = snap_q;   stat_d = stat_q;   out_d = out_q;       pend_d = pend_q;
    run_d = run_q;     armed_d = armed_q; wr_hi_d = wr_hi_q;   rd_hi_d = rd_hi_q;
    snap_v_d = snap_v_q; stat_v_d = stat_v_q;

    if (tick_i) begin
      if (kind == K_STROBE && !out_q) out_d = 1'b1;
      if (pend_q) begin
        count_d = (kind == K_SQUARE) ? reload_even : reload_q;
        pend_d  = 1'b0;
        run_d   = 1'b1;
        armed_d = 1'b1;
      end else if (run_q && gate_i) begin
        unique case (kind)
          K_SQUARE: begin
            if (count_q == TWO) begin
              count_d = reload_even;
              out_d   = ~out_q;
            end else begin
              count_d = count_q - TWO;
            end
          end
          K_STROBE: begin
            count_d = count_q - ONE;
            if (armed_q && count_q == ONE) begin
              out_d   = 1'b0;
              armed_d = 1'b0;
            end
          end
          default: begin
            count_d = count_q - ONE;
            if (count_q == ONE) out_d = 1'b1;
          end
        endcase
      end
    end

    if ((snap_cmd_i || rb_cnt_i) && !snap_v_q) begin
      snap_d   = count_q;
      snap_v_d = 1'b1;
    end
    if (rb_stat_i && !stat_v_q) begin
      stat_d   = BYTE_W'({out_q, pend_q, acc_q, mode_q, 1'b0});
      stat_v_d = 1'b1;
    end

    if (dat_wr_i) begin
      unique case (acc_q)
        ACC_LO: reload_d = {{BYTE_W{1'b0}}, wdata_i};
        ACC_HI: reload_d = {wdata_i, {BYTE_W{1'b0}}};
        default: begin
          if (!wr_hi_q) reload_d[BYTE_W-1:0]     = wdata_i;
          else          reload_d[CNT_W-1:BYTE_W] = wdata_i;
          wr_hi_d = ~wr_hi_q;
        end
      endcase
      if (commit) begin
        pend_d = 1'b1;
        if (kind == K_TERM) out_d = 1'b0;
      end
    end

    if (dat_rd_i) begin
      if (stat_v_q) begin
        stat_v_d = 1'b0;
      end else begin
        if (acc_q == ACC_LOHI) rd_hi_d = ~rd_hi_q;
        if (snap_v_q && last_byte) snap_v_d = 1'b0;
      end
    end

    if (ctl_wr_i) begin
      mode_d   = wdata_i[3:1];
      acc_d    = wdata_i[5:4];
      wr_hi_d  = 1'b0;
      rd_hi_d  = 1'b0;
      run_d    = 1'b0;
      pend_d   = 1'b0;
      armed_d  = 1'b0;
      snap_v_d = 1'b0;
      stat_v_d = 1'b0;
      out_d    = (kind_of(wdata_i[3:1]) != K_TERM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; acc_q <= '0; reload_q <= '0; count_q <= '0;
      snap_q <= '0; stat_q <= '0; out_q <= 1'b0; pend_q <= 1'b0;
      run_q <= 1'b0; armed_q <= 1'b0; wr_hi_q <= 1'b0; rd_hi_q <= 1'b0;
      snap_v_q <= 1'b0; stat_v_q <= 1'b0;
    end else begin
      mode_q <= mode_d; acc_q <= acc_d; reload_q <= reload_d; count_q <= count_d;
      snap_q <= snap_d; stat_q <= stat_d; out_q <= out_d; pend_q <= pend_d;
      run_q <= run_d; armed_q <= armed_d; wr_hi_q <= wr_hi_d; rd_hi_q <= rd_hi_d;
      snap_v_q <= snap_v_d; stat_v_q <= stat_v_d;
    end
  end

  // R2
  seq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> (!wr_hi_q && !rd_hi_q));

  // R5
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_TERM && out_q && !ctl_wr_i && !commit) |=> out_q);

  // R6
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SQUARE && run_q) |-> !count_q[0]);

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_STROBE && !out_q && tick_i && !ctl_wr_i) |=> out_q);

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_v_q && !dat_rd_i && !ctl_wr_i) |=> (snap_v_q && $stable(snap_q)));

endmodule

// File: rtl/tmr_aux.sv
module tmr_aux #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              out2_i,
  output logic              gate2_o,
  output logic              spk_o,
  output logic [BYTE_W-1:0] rdata_o
);

  logic gate_q, gate_d, spk_q, spk_d;

  always_comb begin
    gate_d = gate_q;
    spk_d  = spk_q;
    if (aux_wr_i) begin
      gate_d = wdata_i[0];
      spk_d  = wdata_i[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      spk_q  <= spk_d;
    end
  end

  always_comb begin
    rdata_o    = '0;
    rdata_o[0] = gate_q;
    rdata_o[1] = spk_q;
    rdata_o[4] = out2_i;
  end

  assign gate2_o = gate_q;
  assign spk_o   = spk_q;

  // R12
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_wr_i |=> $stable({gate_q, spk_q}));

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tri_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              aux_wr,
  output logic [BYTE_W-1:0] aux_rdata,
  input  logic [2:0]        tick_en,
  input  logic [1:0]        gate_in,
  output logic [2:0]        tmr_out,
  output logic              spk_en
);

  localparam int NCH  = 3;
  localparam int CH_W = 2;
  localparam logic [CH_W-1:0] CTL_ADDR = 2'd3;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              ctl_hit, is_rb, gate2;
  logic [CH_W-1:0]   sel;
  logic [NCH-1:0]    gate_vec;
  logic [BYTE_W-1:0] ch_rdata [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ctl_hit  = bus_wr && (bus_addr == CTL_ADDR);
  assign sel      = bus_wdata[7:6];
  assign is_rb    = (sel == 2'b11);
  assign gate_vec = {gate2, gate_in};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit, ctl_w, snap_c, rb_c, rb_s, d_wr, d_rd;
    assign hit    = ctl_hit && !is_rb && (sel == CH_W'(g));
    assign ctl_w  = hit && (bus_wdata[5:4] != ACC_SNAP);
    assign snap_c = hit && (bus_wdata[5:4] == ACC_SNAP);
    assign rb_c   = ctl_hit && is_rb && bus_wdata[g+1] && !bus_wdata[5];
    assign rb_s   = ctl_hit && is_rb && bus_wdata[g+1] && !bus_wdata[4];
    assign d_wr   = bus_wr && (bus_addr == CH_W'(g));
    assign d_rd   = bus_rd && (bus_addr == CH_W'(g));

    tmr_channel #(.BYTE_W(BYTE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .tick_i    (tick_en[g]),
      .gate_i    (gate_vec[g]),
      .ctl_wr_i  (ctl_w),
      .snap_cmd_i(snap_c),
      .rb_cnt_i  (rb_c),
      .rb_stat_i (rb_s),
      .dat_wr_i  (d_wr),
      .dat_rd_i  (d_rd),
      .wdata_i   (bus_wdata),
      .rdata_o   (ch_rdata[g]),
      .out_o     (tmr_out[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == CH_W'(i)) bus_rdata = ch_rdata[i];
    end
  end

  tmr_aux #(.BYTE_W(BYTE_W)) u_aux (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .aux_wr_i(aux_wr),
    .wdata_i (bus_wdata),
    .out2_i  (tmr_out[2]),
    .gate2_o (gate2),
    .spk_o   (spk_en),
    .rdata_o (aux_rdata)
  );

  // R13
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == CTL_ADDR) |-> (bus_rdata == '0));

endmodule

// File: tb/tri_interval_timer_test.sv
`timescale 1ns/1ps
module tri_interval_timer_test;

  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd, aux_wr;
  logic [7:0] bus_wdata, bus_rdata, aux_rdata;
  logic [2:0] tick_en, tmr_out;
  logic [1:0] gate_in;
  logic       spk_en;

  int checks = 0;
  int fails  = 0;

  tri_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .aux_wr(aux_wr), .aux_rdata(aux_rdata),
    .tick_en(tick_en), .gate_in(gate_in), .tmr_out(tmr_out), .spk_en(spk_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // fields: ch[43:42] ctl[41:34] value[33:18] level[17] ticks[16:0]
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 8'h30, 16'd5,     1'b1, 17'd6},   // R5 terminal count
    {2'd1, 8'h78, 16'd3,     1'b0, 17'd4},   // R7 strobe
    {2'd0, 8'h36, 16'd10,    1'b0, 17'd6},   // R6 square even
    {2'd0, 8'h36, 16'd9,     1'b0, 17'd5},   // R6 square odd
    {2'd1, 8'h50, 16'd7,     1'b1, 17'd8},   // R3 low byte only
    {2'd0, 8'h20, 16'h0100,  1'b1, 17'd257}, // R3 high byte only
    {2'd2, 8'hB8, 16'd2,     1'b0, 17'd3},   // R12 channel 2 via aux gate
    {2'd1, 8'h76, 16'd4,     1'b0, 17'd3}    // R6 channel 1 square
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic aux_write(input logic [7:0] d);
    bus_wdata = d; aux_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    aux_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic measure(input int ch, input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (tmr_out[ch] !== lvl && n < 70000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1;
    int n, v1, v2, stays;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; aux_wr = 0;
    bus_wdata = '0; tick_en = 3'b111; gate_in = 2'b11;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 outputs", tmr_out, 0);
    chk("R1 spk_en", spk_en, 0);
    chk("R1 aux_rdata", aux_rdata, 0);

    aux_write(8'h01);
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  ch;
      logic [7:0]  ctl;
      logic [15:0] val;
      ch  = VEC[i][43:42];
      ctl = VEC[i][41:34];
      val = VEC[i][33:18];
      wr(2'd3, ctl);
      chk("R2 level after control", tmr_out[ch], !VEC[i][17]);
      if (ctl[5:4] == 2'b01)      wr(ch, val[7:0]);
      else if (ctl[5:4] == 2'b10) wr(ch, val[15:8]);
      else begin wr(ch, val[7:0]); wr(ch, val[15:8]); end
      measure(ch, VEC[i][17], n);
      chk($sformatf("R4 vector %0d tick count", i), n, int'(VEC[i][16:0]));
    end

    // R7 pulse width one tick, no repeat
    wr(2'd3, 8'h78); wr(2'd1, 8'd3); wr(2'd1, 8'd0);
    measure(1, 1'b0, n);
    chk("R7 strobe delay", n, 4);
    idle(1);
    chk("R7 strobe high after one tick", tmr_out[1], 1);
    stays = 0;
    for (int i = 0; i < 12; i++) begin idle(1); if (tmr_out[1]) stays++; end
    chk("R7 no second strobe", stays, 12);

    // R6 continuing square wave
    wr(2'd3, 8'h36); wr(2'd0, 8'd6); wr(2'd0, 8'd0);
    measure(0, 1'b0, n);
    chk("R6 first half", n, 4);
    measure(0, 1'b1, n);
    chk("R6 second half", n, 3);

    // R5 hold high, new count drives low
    wr(2'd3, 8'h30); wr(2'd0, 8'd5); wr(2'd0, 8'd0);
    measure(0, 1'b1, n);
    chk("R5 rise", n, 6);
    idle(20);
    chk("R5 still high", tmr_out[0], 1);
    wr(2'd0, 8'd9); wr(2'd0, 8'd0);
    chk("R5 low after rewrite", tmr_out[0], 0);

    // R2 control write restarts byte sequence
    wr(2'd3, 8'h30); wr(2'd0, 8'hAA);
    wr(2'd3, 8'h30); wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    measure(0, 1'b1, n);
    chk("R2 sequence restart", n, 5);

    // R9 gate holds the count
    gate_in[0] = 1'b0;
    wr(2'd3, 8'h30); wr(2'd0, 8'd5); wr(2'd0, 8'd0);
    idle(20);
    chk("R9 frozen output", tmr_out[0], 0);
    gate_in[0] = 1'b1;
    measure(0, 1'b1, n);
    chk("R9 resumes", n, 5);

    // R10 snapshot while counting
    wr(2'd3, 8'h70); wr(2'd1, 8'hE8); wr(2'd1, 8'h03);
    idle(3);
    wr(2'd3, 8'h40);
    idle(5);
    wr(2'd3, 8'h40);
    rd(2'd1, b0); rd(2'd1, b1); v1 = {b1, b0};
    wr(2'd3, 8'h40);
    rd(2'd1, b0); rd(2'd1, b1); v2 = {b1, b0};
    chk("R10 held snapshot spacing", v1 - v2, 9);
    chk("R10 snapshot below reload", int'(v1 < 1000), 1);

    // R11 capture with status, channels 0 and 2 frozen
    gate_in[0] = 1'b0;
    wr(2'd3, 8'h30); wr(2'd0, 8'h34); wr(2'd0, 8'h12);
    aux_write(8'h00);
    wr(2'd3, 8'h98); wr(2'd2, 8'h56);
    idle(2);
    wr(2'd3, 8'hCA);
    rd(2'd0, b0); chk("R11 ch0 status", b0, 8'h30);
    rd(2'd0, b0); chk("R11 ch0 count low", b0, 8'h34);
    rd(2'd0, b0); chk("R11 ch0 count high", b0, 8'h12);
    rd(2'd2, b0); chk("R11 ch2 status", b0, 8'h98);
    rd(2'd2, b0); chk("R11 ch2 count", b0, 8'h56);
    rd(2'd2, b0); chk("R13 ch2 live low-only", b0, 8'h56);
    rd(2'd0, b0); chk("R13 ch0 live low", b0, 8'h34);
    rd(2'd0, b0); chk("R13 ch0 live high", b0, 8'h12);
    rd(2'd3, b0); chk("R13 control read", b0, 0);

    // R11 reload-pending status bit
    tick_en[1] = 1'b0;
    wr(2'd3, 8'h76); wr(2'd1, 8'h10); wr(2'd1, 8'h00);
    wr(2'd3, 8'hE4);
    rd(2'd1, b0); chk("R11 pending status", b0, 8'hF6);
    tick_en[1] = 1'b1;

    // R12 auxiliary register
    aux_write(8'h02);
    chk("R12 speaker", spk_en, 1);
    chk("R12 aux readback", aux_rdata, 8'h12);

    // R8 zero count means 65536
    gate_in[0] = 1'b1;
    wr(2'd3, 8'h30); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    measure(0, 1'b1, n);
    chk("R8 full range", n, 65537);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule